// File: doc/BRIEF.md
# Load/Store Effective Address Unit

This unit works out where a single-register memory load or store goes. It also works out what, if anything, goes back into the base register. Each request carries a base register value and an offset. The offset is either a 12-bit unsigned immediate or a full 32-bit register value. The request also carries four control bits: direction (add or subtract the offset), indexing phase (pre or post), a writeback request and the access size (byte or word).

Three addressing styles follow from these bits:
- **Pre-indexed without writeback:** the memory address is base ± offset and the base register is left alone. A pre-indexed request with a zero offset is plain register-indirect addressing.
- **Pre-indexed with writeback:** the same address, and that address is also written back to the base register.
- **Post-indexed:** the untouched base is the address, and base ± offset is always written back.

For byte accesses the unit drives a one-hot lane enable and never flags misalignment. For word accesses it enables all lanes and flags any address that is not a multiple of four. Results are registered and appear one clock after the request.

Top module: `agu_core`

## Requirements
- R1: After a synchronous active-low reset, rsp_valid, base_wr_en, misaligned, lane_en, mem_addr and new_base are all zero.
- R2: A request presented with req_valid=1 produces its response, with rsp_valid=1, exactly one clock later. A cycle with req_valid=0 yields rsp_valid=0 and base_wr_en=0 one clock later.
- R3: With off_is_reg=1 the offset is the full 32-bit reg_off. With off_is_reg=0 it is imm_off zero-extended, so the magnitude is 0 to 4095.
- R4: add_up=1 forms base+offset and add_up=0 forms base-offset, both modulo 2^32.
- R5: Pre-indexed without writeback (pre_idx=1, wb_req=0): mem_addr is the offset sum, base_wr_en=0 and new_base equals the base.
- R6: Pre-indexed with writeback (pre_idx=1, wb_req=1): mem_addr is the offset sum, base_wr_en=1 and new_base is the offset sum.
- R7: Post-indexed (pre_idx=0): mem_addr is the unmodified base, base_wr_en=1 whatever wb_req is, and new_base is the offset sum.
- R8: Register-indirect use (pre_idx=1 with an offset of zero) gives mem_addr equal to the base.
- R9: Byte access (is_byte=1): only lane_en bit mem_addr[1:0] is set and misaligned=0 for every address.
- R10: Word access (is_byte=0): lane_en=4'b1111, and misaligned=1 exactly when mem_addr[1:0] is nonzero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present this cycle |
| base_val | input | 32 | Base register value |
| imm_off | input | 12 | Unsigned immediate offset |
| reg_off | input | 32 | Register offset value |
| off_is_reg | input | 1 | 1 selects reg_off, 0 selects imm_off |
| add_up | input | 1 | 1 adds the offset, 0 subtracts it |
| pre_idx | input | 1 | 1 pre-indexed, 0 post-indexed |
| wb_req | input | 1 | Writeback request for pre-indexed mode |
| is_byte | input | 1 | 1 byte access, 0 word access |
| rsp_valid | output | 1 | Response valid |
| mem_addr | output | 32 | Effective memory address |
| lane_en | output | 4 | Byte lane enables |
| misaligned | output | 1 | Word access not on a 4-byte boundary |
| new_base | output | 32 | Value for the base register |
| base_wr_en | output | 1 | Base register writeback enable |

## Verification
In one response, a post-indexed request must report two different values at once: the untouched base as the address and the offset sum as the writeback value. The lane decode must also follow the address actually used, not the sum. The bench provokes this with post-indexed requests that use nonzero offsets in both directions, on byte and word sizes, with bases whose low two bits differ from those of the sum. It judges mem_addr, new_base, lane_en and misaligned separately against a bench-side model. A post-indexed request with wb_req=0 is included to show that writeback still happens.

// File: rtl/agu_pkg.sv
// Package: shared sizing for the load/store address unit.
// Assumes a byte-addressed memory with power-of-two word width.
package agu_pkg;
    localparam int unsigned AGU_ADDR_W = 32;
    localparam int unsigned AGU_IMM_W  = 12;
    localparam int unsigned AGU_LANES  = 4;

    // Combined result of one address computation.
    typedef struct packed {
        logic [AGU_ADDR_W-1:0] addr;
        logic [AGU_LANES-1:0]  lanes;
        logic                  mis;
        logic [AGU_ADDR_W-1:0] nbase;
        logic                  wb;
    } agu_result_t;
endpackage

// File: rtl/agu_offset_sel.sv
// Module: chooses the offset source.
// An immediate is unsigned and zero-extended; a register offset is used whole.
// Assumes IMM_W < ADDR_W.
module agu_offset_sel #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned IMM_W  = 12
) (
    input  logic [IMM_W-1:0]  imm_off,
    input  logic [ADDR_W-1:0] reg_off,
    input  logic              off_is_reg,
    output logic [ADDR_W-1:0] off_mag
);
    localparam int unsigned PAD_W = ADDR_W - IMM_W;

    // Pick the register offset or the zero-extended immediate.
    always_comb begin
        if (off_is_reg) off_mag = reg_off;
        else            off_mag = {{PAD_W{1'b0}}, imm_off};
    end
endmodule

// File: rtl/agu_adder.sv
// Module: adds or subtracts the offset magnitude from the base, modulo 2^ADDR_W.
// Assumes the offset is an unsigned magnitude; direction is given separately.
module agu_adder #(
    parameter int unsigned ADDR_W = 32
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] off_mag,
    input  logic              add_up,
    output logic [ADDR_W-1:0] sum
);
    // Apply the offset in the requested direction.
    always_comb begin
        if (add_up) sum = base + off_mag;
        else        sum = base - off_mag;
    end
endmodule

// File: rtl/agu_lane_decode.sv
// Module: turns the low address bits into byte lane enables and a misalignment flag.
// A byte access selects one lane; a word access selects all lanes and is
// misaligned when the low bits are not zero. Assumes LANES is a power of two.
module agu_lane_decode #(
    parameter int unsigned LANES = 4,
    localparam int unsigned IDX_W = $clog2(LANES)
) (
    input  logic [IDX_W-1:0] addr_lo,
    input  logic             is_byte,
    output logic [LANES-1:0] lane_en,
    output logic             misaligned
);
    // One enable per lane: set for its own index on byte access, always on word access.
    for (genvar g = 0; g < LANES; g++) begin : g_lane
        assign lane_en[g] = !is_byte || (addr_lo == IDX_W'(g));
    end

    // Flag a word access whose address is off a word boundary.
    always_comb misaligned = !is_byte && (addr_lo != '0);
endmodule

// File: rtl/agu_core.sv
// Module: load/store effective address unit (top).
// Computes the memory address, the lane enables, the new base value and the
// base writeback enable for pre-indexed, pre-indexed-with-writeback and
// post-indexed requests. The result is registered: one cycle of latency.
// Assumes the requester supplies a stable request only in cycles with req_valid.
module agu_core
    import agu_pkg::*;
#(
    parameter int unsigned ADDR_W = AGU_ADDR_W,
    parameter int unsigned IMM_W  = AGU_IMM_W,
    parameter int unsigned LANES  = AGU_LANES
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    input  logic [ADDR_W-1:0] base_val,
    input  logic [IMM_W-1:0]  imm_off,
    input  logic [ADDR_W-1:0] reg_off,
    input  logic              off_is_reg,
    input  logic              add_up,
    input  logic              pre_idx,
    input  logic              wb_req,
    input  logic              is_byte,
    output logic              rsp_valid,
    output logic [ADDR_W-1:0] mem_addr,
    output logic [LANES-1:0]  lane_en,
    output logic              misaligned,
    output logic [ADDR_W-1:0] new_base,
    output logic              base_wr_en
);
    localparam int unsigned IDX_W = $clog2(LANES);

    logic [ADDR_W-1:0] off_mag;
    logic [ADDR_W-1:0] sum;
    logic [ADDR_W-1:0] addr_c;
    logic [LANES-1:0]  lanes_c;
    logic              mis_c;
    logic              wb_c;
    logic [ADDR_W-1:0] nbase_c;

    agu_offset_sel #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) u_off (
        .imm_off    (imm_off),
        .reg_off    (reg_off),
        .off_is_reg (off_is_reg),
        .off_mag    (off_mag)
    );

    agu_adder #(.ADDR_W(ADDR_W)) u_add (
        .base    (base_val),
        .off_mag (off_mag),
        .add_up  (add_up),
        .sum     (sum)
    );

    // Address is the sum when pre-indexed, the untouched base when post-indexed.
    always_comb addr_c = pre_idx ? sum : base_val;

    // Post-indexed always writes back; pre-indexed only on request.
    always_comb wb_c = !pre_idx || wb_req;

    // Base value offered for writeback; the original base when none happens.
    always_comb nbase_c = wb_c ? sum : base_val;

    agu_lane_decode #(.LANES(LANES)) u_lane (
        .addr_lo    (addr_c[IDX_W-1:0]),
        .is_byte    (is_byte),
        .lane_en    (lanes_c),
        .misaligned (mis_c)
    );

    // Result register: capture a request, clear the strobes when idle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rsp_valid  <= 1'b0;
            base_wr_en <= 1'b0;
            mem_addr   <= '0;
            lane_en    <= '0;
            misaligned <= 1'b0;
            new_base   <= '0;
        end else begin
            rsp_valid  <= req_valid;
            base_wr_en <= req_valid && wb_c;
            if (req_valid) begin
                mem_addr   <= addr_c;
                lane_en    <= lanes_c;
                misaligned <= mis_c;
                new_base   <= nbase_c;
            end
        end
    end

    // Assertions guarding the registered result.
    AST_WB_ONLY_WITH_RSP: assert property (@(posedge clk) disable iff (!rst_n)
        base_wr_en |-> rsp_valid); // R2
    AST_RSP_FOLLOWS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && req_valid) |=> rsp_valid); // R2
    AST_POST_ALWAYS_WB: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && req_valid && !pre_idx) |=> base_wr_en); // R7
    AST_POST_ADDR_IS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && req_valid && !pre_idx) |=> (mem_addr == $past(base_val))); // R7
    AST_PRE_NOWB_HOLDS_BASE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && req_valid && pre_idx && !wb_req) |=> (!base_wr_en && new_base == $past(base_val))); // R5
    AST_LANE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |-> ($countones(lane_en) == 1 || lane_en == '1)); // R9
    AST_MISALIGN_WORD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
        misaligned |-> (lane_en == '1 && mem_addr[IDX_W-1:0] != '0)); // R10
endmodule

// File: tb/agu_core_tb.sv
module agu_core_tb;
    localparam int CLK_PERIOD = 10;
    localparam int WATCHDOG_CYC = 20000;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic [31:0] base_val = '0;
    logic [11:0] imm_off = '0;
    logic [31:0] reg_off = '0;
    logic        off_is_reg = 1'b0;
    logic        add_up = 1'b0;
    logic        pre_idx = 1'b0;
    logic        wb_req = 1'b0;
    logic        is_byte = 1'b0;
    logic        rsp_valid;
    logic [31:0] mem_addr;
    logic [3:0]  lane_en;
    logic        misaligned;
    logic [31:0] new_base;
    logic        base_wr_en;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    agu_core u_dut (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .base_val(base_val),
        .imm_off(imm_off), .reg_off(reg_off), .off_is_reg(off_is_reg),
        .add_up(add_up), .pre_idx(pre_idx), .wb_req(wb_req), .is_byte(is_byte),
        .rsp_valid(rsp_valid), .mem_addr(mem_addr), .lane_en(lane_en),
        .misaligned(misaligned), .new_base(new_base), .base_wr_en(base_wr_en)
    );

    // Compare one value, count it, report a mismatch.
    task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_sum(logic [31:0] b, logic [11:0] im, logic [31:0] ro,
                                            logic isreg, logic up);
        logic [31:0] o;
        o = isreg ? ro : {20'd0, im};
        return up ? b + o : b - o;
    endfunction

    function automatic logic [3:0] exp_lanes(logic [31:0] a, logic byt);
        return byt ? (4'b0001 << a[1:0]) : 4'b1111;
    endfunction

    // Drive one request at a falling edge and check its response one clock later.
    task automatic issue(logic [31:0] b, logic [11:0] im, logic [31:0] ro, logic isreg,
                         logic up, logic pre, logic wb, logic byt);
        logic [31:0] s, a, nb;
        logic        w;
        base_val = b; imm_off = im; reg_off = ro; off_is_reg = isreg;
        add_up = up; pre_idx = pre; wb_req = wb; is_byte = byt; req_valid = 1'b1;
        s  = exp_sum(b, im, ro, isreg, up);
        a  = pre ? s : b;
        w  = !pre || wb;
        nb = w ? s : b;
        @(posedge clk); @(negedge clk);
        req_valid = 1'b0;
        chk("R2", "rsp_valid", {31'd0, rsp_valid}, 32'd1);
        if (!pre) begin
            chk("R7", "mem_addr", mem_addr, a);
            chk("R7", "base_wr_en", {31'd0, base_wr_en}, 32'd1);
            chk("R7", "new_base", new_base, nb);
        end else if (wb) begin
            chk("R6", "mem_addr", mem_addr, a);
            chk("R6", "base_wr_en", {31'd0, base_wr_en}, 32'd1);
            chk("R6", "new_base", new_base, nb);
        end else begin
            chk("R5", "mem_addr", mem_addr, a);
            chk("R5", "base_wr_en", {31'd0, base_wr_en}, 32'd0);
            chk("R5", "new_base", new_base, nb);
        end
        if (byt) begin
            chk("R9", "lane_en", {28'd0, lane_en}, {28'd0, exp_lanes(a, 1'b1)});
            chk("R9", "misaligned", {31'd0, misaligned}, 32'd0);
        end else begin
            chk("R10", "lane_en", {28'd0, lane_en}, 32'hF);
            chk("R10", "misaligned", {31'd0, misaligned}, {31'd0, a[1:0] != 2'b00});
        end
    endtask

    initial begin : wd
        repeat (WATCHDOG_CYC) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin : main
        int unsigned seed_dummy;
        seed_dummy = $urandom(32'd20240611);
        repeat (3) @(negedge clk);
        // R1 reset state
        chk("R1", "rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R1", "base_wr_en", {31'd0, base_wr_en}, 32'd0);
        chk("R1", "misaligned", {31'd0, misaligned}, 32'd0);
        chk("R1", "lane_en", {28'd0, lane_en}, 32'd0);
        chk("R1", "mem_addr", mem_addr, 32'd0);
        chk("R1", "new_base", new_base, 32'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R8 register-indirect: zero offset, pre-indexed
        issue(32'h0000_1234, 12'd0, 32'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        chk("R8", "mem_addr", mem_addr, 32'h0000_1234);
        // R3 immediate maximum 4095 zero-extended
        issue(32'h0000_1000, 12'hFFF, 32'hDEAD_BEEF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b1);
        chk("R3", "imm max", mem_addr, 32'h0000_1FFF);
        // R3 register offset full width
        issue(32'h0000_0010, 12'hFFF, 32'h8000_0000, 1'b1, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R3", "reg off", new_base, 32'h8000_0010);
        // R4 subtract wraps below zero
        issue(32'h0000_0002, 12'd3, 32'd0, 1'b0, 1'b0, 1'b1, 1'b1, 1'b1);
        chk("R4", "wrap sub", new_base, 32'hFFFF_FFFF);
        // R4 add wraps above max
        issue(32'hFFFF_FFFF, 12'd1, 32'd0, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0);
        chk("R4", "wrap add", mem_addr, 32'd0);
        // R7 post-indexed with wb_req low still writes back; address is base
        issue(32'h0000_0103, 12'd5, 32'd0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b1);
        chk("R7", "lane from base", {28'd0, lane_en}, 32'h8);
        issue(32'h0000_0100, 12'd2, 32'd0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0);
        chk("R10", "post aligned", {31'd0, misaligned}, 32'd0);
        // R10 word misaligned at pre-indexed address
        issue(32'h0000_0100, 12'd6, 32'd0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0);
        // R2 idle cycle gives no response
        @(posedge clk); @(negedge clk);
        chk("R2", "idle rsp_valid", {31'd0, rsp_valid}, 32'd0);
        chk("R2", "idle base_wr_en", {31'd0, base_wr_en}, 32'd0);

        // Random mix
        for (int i = 0; i < 400; i++) begin
            issue($urandom, 12'($urandom), $urandom, 1'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom));
            if (($urandom % 8) == 0) begin
                @(posedge clk); @(negedge clk);
                chk("R2", "gap rsp_valid", {31'd0, rsp_valid}, 32'd0);
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule